// File: doc/BRIEF.md
# Configurable Sequential Logic Cell

This cell is one tile of a programmable logic fabric. A gated four-way multiplexer picks one of four data lines; its two select bits are not wired straight in but are each formed from a pair of gating inputs, so that the cell can absorb a small piece of logic in front of the selection. The multiplexer result goes without any intermediate register into one storage element, so any function the multiplexer alone can form can also be held without adding a stage.

Static configuration decides two things per cell. One bit makes the storage element either a level-sensitive latch or a rising-edge flip-flop. A two-bit field picks which of three global clock networks (two general networks and one fast network) drives it. An active-high clear forces the stored value to zero at any time, whatever the mode and the clock.

Top module: `seqcell`

## Requirements
- R1: The multiplexer index is {S1,S0}: index 00 selects `din_00`, 01 selects `din_01`, 10 selects `din_10`, 11 selects `din_11`, and the selected value is what the storage element takes in.
- R2: S1 is the OR of `hi_gate_a` and `hi_gate_b`; S1 is 1 when either or both are 1.
- R3: S0 is the AND of `lo_gate_a` and `lo_gate_b`; S0 is 1 only when both are 1.
- R4: With `cfg_latch` = 0, `q` takes the multiplexer result on each rising edge of the selected clock network and holds it between edges, whatever the data and gating inputs do.
- R5: With `cfg_latch` = 1, `q` follows the multiplexer result while the selected clock network is high and holds the last value while it is low.
- R6: While `clr` is 1, `q` is 0 at once, with no clock edge needed, in both modes; clock edges and an open latch have no effect until `clr` returns to 0.
- R7: `cfg_clk_sel` picks the clock network: 00 gives `net_a`, 01 gives `net_b`, 10 gives `net_h`, 11 gives `net_a`; transitions on the networks not picked leave `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din_00 | input | DW | Data chosen at index 00 |
| din_01 | input | DW | Data chosen at index 01 |
| din_10 | input | DW | Data chosen at index 10 |
| din_11 | input | DW | Data chosen at index 11 |
| hi_gate_a | input | 1 | First input of the upper select bit (ORed) |
| hi_gate_b | input | 1 | Second input of the upper select bit (ORed) |
| lo_gate_a | input | 1 | First input of the lower select bit (ANDed) |
| lo_gate_b | input | 1 | Second input of the lower select bit (ANDed) |
| clr | input | 1 | Asynchronous clear, active high |
| net_a | input | 1 | General clock network A |
| net_b | input | 1 | General clock network B |
| net_h | input | 1 | Fast clock network |
| cfg_clk_sel | input | 2 | Static clock network choice |
| cfg_latch | input | 1 | Static mode: 1 latch, 0 flip-flop |
| q | output | DW | Stored value |

## Verification
The data lines are driven with one-hot and inverted one-hot patterns at each of the four indices, so a swapped or stuck index shows as a wrong bit. All four combinations of each gating pair are applied while the other select bit is fixed, which separates OR from AND and from a plain pass-through of one input. Data is changed between edges, with the unpicked networks toggling, and with the latch open and closed, which tells edge capture from level transparency and a correct clock choice from a wrong one; clear is raised between edges and during an open latch to show that it acts without a clock.

// File: rtl/seqcell_pkg.sv
package seqcell_pkg;

  typedef enum logic [1:0] {
    NET_SEL_A   = 2'b00,
    NET_SEL_B   = 2'b01,
    NET_SEL_H   = 2'b10,
    NET_SEL_RSV = 2'b11
  } net_sel_e;

  localparam int unsigned NUM_WAYS = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_WAYS);

endpackage

// File: rtl/seqcell_gate_mux.sv
module seqcell_gate_mux
  import seqcell_pkg::*;
#(
  parameter int unsigned DW = 1
) (
  input  logic [DW-1:0] way_0,
  input  logic [DW-1:0] way_1,
  input  logic [DW-1:0] way_2,
  input  logic [DW-1:0] way_3,
  input  logic          hi_a,
  input  logic          hi_b,
  input  logic          lo_a,
  input  logic          lo_b,
  output logic [DW-1:0] y
);

  logic             sel_hi;
  logic             sel_lo;
  logic [IDX_W-1:0] idx;

  always_comb begin
    sel_hi = hi_a | hi_b;
    sel_lo = lo_a & lo_b;
    idx    = {sel_hi, sel_lo};
  end

  always_comb begin
    unique case (idx)
      2'b00:   y = way_0;
      2'b01:   y = way_1;
      2'b10:   y = way_2;
      default: y = way_3;
    endcase
  end

endmodule

// File: rtl/seqcell_clk_pick.sv
module seqcell_clk_pick
  import seqcell_pkg::*;
(
  input  logic       net_a,
  input  logic       net_b,
  input  logic       net_h,
  input  logic [1:0] sel,
  output logic       clk_out
);

  net_sel_e sel_e;

  always_comb begin
    sel_e = net_sel_e'(sel);
    unique case (sel_e)
      NET_SEL_B: clk_out = net_b;
      NET_SEL_H: clk_out = net_h;
      default:   clk_out = net_a;
    endcase
  end

endmodule

// File: rtl/seqcell_store.sv
module seqcell_store #(
  parameter int unsigned DW = 1
) (
  input  logic          clk_g,
  input  logic          clr,
  input  logic          latch_mode,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_lat;
  logic [DW-1:0] q_ff;
  logic [DW-1:0] q_ff_nxt;

  // Level-sensitive element: open while the gate clock is high.
  always_latch begin
    if (clr) begin
      q_lat = '0;
    end else if (clk_g) begin
      q_lat = d;
    end
  end

  // Edge element: next-state and register kept apart.
  always_comb begin
    q_ff_nxt = d;
  end

  always_ff @(posedge clk_g or posedge clr) begin
    if (clr) begin
      q_ff <= '0;
    end else begin
      q_ff <= q_ff_nxt;
    end
  end

  always_comb begin
    q = latch_mode ? q_lat : q_ff;
  end

endmodule

// File: rtl/seqcell.sv
module seqcell
  import seqcell_pkg::*;
#(
  parameter int unsigned DW = 1
) (
  input  logic [DW-1:0] din_00,
  input  logic [DW-1:0] din_01,
  input  logic [DW-1:0] din_10,
  input  logic [DW-1:0] din_11,
  input  logic          hi_gate_a,
  input  logic          hi_gate_b,
  input  logic          lo_gate_a,
  input  logic          lo_gate_b,
  input  logic          clr,
  input  logic          net_a,
  input  logic          net_b,
  input  logic          net_h,
  input  logic [1:0]    cfg_clk_sel,
  input  logic          cfg_latch,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mux_y;
  logic          cell_clk;

  seqcell_gate_mux #(.DW(DW)) u_mux (
    .way_0 (din_00),
    .way_1 (din_01),
    .way_2 (din_10),
    .way_3 (din_11),
    .hi_a  (hi_gate_a),
    .hi_b  (hi_gate_b),
    .lo_a  (lo_gate_a),
    .lo_b  (lo_gate_b),
    .y     (mux_y)
  );

  seqcell_clk_pick u_clk (
    .net_a   (net_a),
    .net_b   (net_b),
    .net_h   (net_h),
    .sel     (cfg_clk_sel),
    .clk_out (cell_clk)
  );

  seqcell_store #(.DW(DW)) u_store (
    .clk_g      (cell_clk),
    .clr        (clr),
    .latch_mode (cfg_latch),
    .d          (mux_y),
    .q          (q)
  );

endmodule

// File: rtl/seqcell_chk.sv
module seqcell_chk #(
  parameter int unsigned DW = 1
) (
  input logic          clr,
  input logic          net_a,
  input logic          net_h,
  input logic [1:0]    cfg_clk_sel,
  input logic          cfg_latch,
  input logic [DW-1:0] mux_y,
  input logic [DW-1:0] q
);

  logic on_a;
  logic on_h;
  logic [2:0] cfg_word;

  always_comb begin
    on_a     = (cfg_clk_sel == 2'b00) || (cfg_clk_sel == 2'b11);
    on_h     = (cfg_clk_sel == 2'b10);
    cfg_word = {cfg_latch, cfg_clk_sel};
  end

  // R4 / R7: flip-flop on network A holds what the mux gave at the last edge
  p_ff_capture_a_r4: assert property (@(posedge net_a) disable iff (clr)
    (on_a && !cfg_latch) |=> ((q == $past(mux_y)) || !$stable(cfg_word)));

  // R7: fast network drives the cell when picked
  p_ff_capture_h_r7: assert property (@(posedge net_h) disable iff (clr)
    (on_h && !cfg_latch) |=> ((q == $past(mux_y)) || !$stable(cfg_word)));

  // R5: latch is transparent just before the gate closes
  p_latch_open_r5: assert property (@(negedge net_a) disable iff (clr)
    (on_a && cfg_latch) |-> (q == mux_y));

  // R6: clear forces zero regardless of edges
  p_clr_zero_r6: assert property (@(posedge net_a) disable iff (1'b0)
    clr |-> (q == '0));

endmodule

bind seqcell seqcell_chk #(.DW(DW)) u_chk (
  .clr         (clr),
  .net_a       (net_a),
  .net_h       (net_h),
  .cfg_clk_sel (cfg_clk_sel),
  .cfg_latch   (cfg_latch),
  .mux_y       (mux_y),
  .q           (q)
);

// File: tb/seqcell_test.sv
`timescale 1ns/1ps
module seqcell_test;

  localparam int unsigned DW = 1;

  logic          tb_clk;
  logic [DW-1:0] din_00, din_01, din_10, din_11;
  logic          hi_gate_a, hi_gate_b, lo_gate_a, lo_gate_b;
  logic          clr, net_a, net_b, net_h;
  logic [1:0]    cfg_clk_sel;
  logic          cfg_latch;
  logic [DW-1:0] q;

  int n_cmp;
  int n_bad;
  int wd_cnt;
  bit done;

  seqcell #(.DW(DW)) uut (
    .din_00(din_00), .din_01(din_01), .din_10(din_10), .din_11(din_11),
    .hi_gate_a(hi_gate_a), .hi_gate_b(hi_gate_b),
    .lo_gate_a(lo_gate_a), .lo_gate_b(lo_gate_b),
    .clr(clr), .net_a(net_a), .net_b(net_b), .net_h(net_h),
    .cfg_clk_sel(cfg_clk_sel), .cfg_latch(cfg_latch), .q(q)
  );

  initial tb_clk = 1'b0;
  always #2 tb_clk = ~tb_clk;

  always @(posedge tb_clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt > 20000 && !done) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] exp);
    n_cmp = n_cmp + 1;
    if (q !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%b expected=%b", tag, q, exp);
    end
  endtask

  task automatic gates(input logic h1, input logic h2, input logic l1, input logic l2);
    hi_gate_a = h1; hi_gate_b = h2; lo_gate_a = l1; lo_gate_b = l2;
    #1;
  endtask

  task automatic data(input logic [3:0] v);
    din_00 = v[0]; din_01 = v[1]; din_10 = v[2]; din_11 = v[3];
    #1;
  endtask

  // which: 0 = A, 1 = B, 2 = H
  task automatic pulse(input int which);
    #1;
    case (which)
      1: net_b = 1'b1;
      2: net_h = 1'b1;
      default: net_a = 1'b1;
    endcase
    #2;
    net_a = 1'b0; net_b = 1'b0; net_h = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    check("R6 reset state", 1'b0);
    pulse(0);
    check("R6 edge during clear", 1'b0);
    clr = 1'b0;
    #1;
  endtask

  task automatic t_index();
    cfg_latch = 1'b0; cfg_clk_sel = 2'b00;
    for (int i = 0; i < 4; i++) begin
      gates(i[1], 1'b0, i[0], i[0]);
      data(4'b0001 << i);
      pulse(0);
      check("R1 one-hot index", 1'b1);
      data(~(4'b0001 << i));
      pulse(0);
      check("R1 inverted index", 1'b0);
    end
  endtask

  task automatic t_or();
    data(4'b0100);
    for (int i = 0; i < 4; i++) begin
      gates(i[1], i[0], 1'b0, 1'b0);
      pulse(0);
      check("R2 OR gating", (i != 0) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_and();
    data(4'b0010);
    for (int i = 0; i < 4; i++) begin
      gates(1'b0, 1'b0, i[1], i[0]);
      pulse(0);
      check("R3 AND gating", (i == 3) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_ff_hold();
    gates(0, 0, 0, 0);
    data(4'b0001);
    pulse(0);
    check("R4 capture", 1'b1);
    data(4'b0000);
    #3;
    check("R4 hold without edge", 1'b1);
    pulse(1);
    pulse(2);
    check("R7 other networks ignored", 1'b1);
    pulse(0);
    check("R4 next edge", 1'b0);
  endtask

  task automatic t_net_sel();
    gates(0, 0, 0, 0);
    cfg_clk_sel = 2'b01;
    data(4'b0001);
    pulse(0); pulse(2);
    check("R7 sel 01 ignores A and H", 1'b0);
    pulse(1);
    check("R7 sel 01 uses B", 1'b1);
    cfg_clk_sel = 2'b10;
    data(4'b0000);
    pulse(0); pulse(1);
    check("R7 sel 10 ignores A and B", 1'b1);
    pulse(2);
    check("R7 sel 10 uses H", 1'b0);
    cfg_clk_sel = 2'b11;
    data(4'b0001);
    pulse(1); pulse(2);
    check("R7 sel 11 ignores B and H", 1'b0);
    pulse(0);
    check("R7 sel 11 uses A", 1'b1);
  endtask

  task automatic t_latch();
    cfg_clk_sel = 2'b00; cfg_latch = 1'b1;
    gates(0, 0, 0, 0);
    data(4'b0000);
    #1; net_a = 1'b1; #1;
    check("R5 open follows 0", 1'b0);
    data(4'b0001);
    check("R5 open follows 1", 1'b1);
    gates(1, 0, 0, 0);
    check("R5 open follows select", 1'b0);
    gates(0, 0, 0, 0);
    #1; net_a = 1'b0; #1;
    data(4'b0000);
    #2;
    check("R5 closed holds", 1'b1);
    pulse(1);
    check("R7 latch ignores B", 1'b1);
  endtask

  task automatic t_clear();
    // latch mode, gate open
    data(4'b0001);
    net_a = 1'b1; #1;
    clr = 1'b1; #1;
    check("R6 clear open latch", 1'b0);
    net_a = 1'b0; #1;
    clr = 1'b0; #1;
    check("R6 latch stays cleared", 1'b0);
    // flip-flop mode, between edges
    cfg_latch = 1'b0;
    pulse(0);
    check("R4 reload before clear", 1'b1);
    #1; clr = 1'b1; #1;
    check("R6 async clear flop", 1'b0);
    pulse(0);
    check("R6 edge ignored in clear", 1'b0);
    clr = 1'b0; #1;
    check("R6 stays zero after release", 1'b0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; wd_cnt = 0; done = 1'b0;
    clr = 1'b1;
    net_a = 1'b0; net_b = 1'b0; net_h = 1'b0;
    cfg_clk_sel = 2'b00; cfg_latch = 1'b0;
    din_00 = '0; din_01 = '0; din_10 = '0; din_11 = '0;
    hi_gate_a = 1'b0; hi_gate_b = 1'b0; lo_gate_a = 1'b0; lo_gate_b = 1'b0;
    #5;
    t_reset();
    t_index();
    t_or();
    t_and();
    t_ff_hold();
    t_net_sel();
    t_latch();
    t_clear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule